// File: doc/BRIEF.md
# Ready-Latency-One Stream Adapter

This block joins an upstream producer that reacts to back-pressure one cycle late to a downstream consumer that uses a strict valid/ready handshake. When the adapter lowers its upstream ready, the producer may still deliver one beat in that same cycle. That beat must not be lost. The adapter therefore keeps a small buffer that always has one slot spare for it. Beats the producer offers after that grace cycle are dropped until ready rises again.

Toward the consumer, a beat moves only in a cycle where valid and ready are both high. While the consumer stalls, the offered beat and its end-of-frame flag hold still. The upstream ready is the inverse of a full flag. That flag is raised once the buffer holds DEPTH-1 beats, which leaves the final slot for the late beat. With the consumer always ready, the adapter moves one beat per cycle.

Top module: `rl1_stream_adapter`

## Requirements
- R1: During and after synchronous active-high reset, the buffer is empty, `out_valid` is low and `in_ready` is high.
- R2: A beat with `in_valid` high in a cycle where `in_ready` is high is accepted.
- R3: A beat offered in the first cycle that `in_ready` is low, when `in_ready` was high in the cycle before, is accepted.
- R4: A beat offered in a cycle where `in_ready` is low and was also low in the cycle before is ignored and never reaches the output.
- R5: `in_ready` is low exactly when the buffer holds DEPTH-1 or more beats. A stalled, empty adapter fed continuously therefore accepts DEPTH-1 beats with ready high, plus one late beat.
- R6: A beat leaves on `out_*` only when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` stay unchanged.
- R7: Accepted beats leave in the order they were accepted, each exactly once, under any pattern of `out_ready`.
- R8: With `out_ready` held high and a beat offered every cycle, `in_ready` stays high and one beat leaves per cycle, one cycle after it is accepted.
- R9: `out_last` carries the `in_last` value that was accepted with the same beat.
- R10: The buffer never holds more than DEPTH beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream beat present |
| in_data | input | DATA_W | Upstream beat payload |
| in_last | input | 1 | Upstream end-of-frame flag |
| in_ready | output | 1 | Back-pressure to upstream; the producer may send one more beat after it falls |
| out_valid | output | 1 | Downstream beat present |
| out_data | output | DATA_W | Downstream beat payload |
| out_last | output | 1 | Downstream end-of-frame flag |
| out_ready | input | 1 | Downstream accepts the beat in this cycle |

## Verification
A continuous stream against an always-ready consumer separates a design with full throughput from one that inserts bubbles or drops ready without cause.

A fill phase holds the consumer stalled while the producer offers a beat every cycle. It counts how many beats are taken. This tells a correct buffer apart from three faults:
- one that reserves no slot,
- one that drops the late beat,
- one that takes beats after the grace cycle.

A long pseudo-random phase runs valid, ready and last together. It tests ordering, last-flag pairing and output stability against a scoreboard queue. This exposes pointer, wrap and hold faults.

// File: rtl/rl1_pkg.sv
package rl1_pkg;
  function automatic int occ_width(input int depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int ptr_width(input int depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/rl1_accept_gate.sv
module rl1_accept_gate (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic full,
  output logic in_ready,
  output logic accept
);
  logic ready_d;

  assign in_ready = ~full;
  assign accept   = in_valid & (in_ready | ready_d);

  always_ff @(posedge clk) begin
    if (rst) ready_d <= 1'b0;
    else     ready_d <= in_ready;
  end
endmodule

// File: rtl/rl1_occupancy.sv
module rl1_occupancy #(
  parameter int DEPTH = 4,
  parameter int PW    = 2,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty
);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_AT  = CW'(DEPTH - 1);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign full  = (occ >= FULL_AT);
  assign empty = (occ == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/rl1_store.sv
module rl1_store #(
  parameter int W     = 17,
  parameter int DEPTH = 4,
  parameter int PW    = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [PW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && (waddr == PW'(i))) slot_q[i] <= wdata;
    end
  end

  assign rdata = slot_q[raddr];
endmodule

// File: rtl/rl1_stream_adapter.sv
module rl1_stream_adapter #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready
);
  localparam int PW = rl1_pkg::ptr_width(DEPTH);
  localparam int CW = rl1_pkg::occ_width(DEPTH);
  localparam int W  = DATA_W + 1;

  logic          accept, pop, full, empty;
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;
  logic [W-1:0]  rd_word;

  rl1_accept_gate u_gate (
    .clk(clk), .rst(rst), .in_valid(in_valid), .full(full),
    .in_ready(in_ready), .accept(accept)
  );

  rl1_occupancy #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_occ (
    .clk(clk), .rst(rst), .push(accept), .pop(pop),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .occ(occ), .full(full), .empty(empty)
  );

  rl1_store #(.W(W), .DEPTH(DEPTH), .PW(PW)) u_store (
    .clk(clk), .we(accept), .waddr(wr_ptr), .wdata({in_last, in_data}),
    .raddr(rd_ptr), .rdata(rd_word)
  );

  assign out_valid = ~empty;
  assign pop       = out_valid & out_ready;
  assign out_data  = rd_word[DATA_W-1:0];
  assign out_last  = rd_word[DATA_W];
endmodule

// File: rtl/rl1_adapter_chk.sv
module rl1_adapter_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int CW     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last,
  input logic              out_ready,
  input logic [CW-1:0]     occ
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (!out_valid && in_ready)); // R1

  AST_READY_FULL: assert property (@(posedge clk) disable iff (rst)
    in_ready == (int'(occ) < DEPTH - 1)); // R5

  AST_LATE_BEAT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_ready && $past(in_ready)) |=>
      int'(occ) == int'($past(occ)) + 1 - int'($past(out_valid && out_ready))); // R3

  AST_IGNORE_LATE: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !$past(in_ready)) |=>
      int'(occ) == int'($past(occ)) - int'($past(out_valid && out_ready))); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_last))); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    int'(occ) <= DEPTH); // R10
endmodule

bind rl1_stream_adapter rl1_adapter_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
  .out_ready(out_ready), .occ(occ)
);

// File: tb/rl1_stream_adapter_tb.sv
module rl1_stream_adapter_tb;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_last = 1'b0;
  logic              in_ready;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;
  logic              out_last;
  logic              out_ready = 1'b0;

  always #10 clk = ~clk;

  rl1_stream_adapter #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  logic [DATA_W:0]   exp_q[$];
  int                errors = 0;
  int                checks = 0;
  int                n_acc  = 0;
  int                n_out  = 0;
  logic              ready_prev = 1'b0;
  logic [DATA_W-1:0] seq = 16'h0100;
  logic [15:0]       lfsr = 16'hACE1;
  bit                finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; pushes beats the protocol says are taken.
  task automatic cycle(input bit v, input bit l, input bit ordy);
    @(negedge clk);
    in_valid  = v;
    in_data   = seq;
    in_last   = l;
    out_ready = ordy;
    #1;
    if (v && (in_ready || ready_prev)) begin
      exp_q.push_back({l, seq});
      n_acc++;
    end
    if (v) seq = seq + 1'b1;
    ready_prev = in_ready;
  endtask

  // Monitor: pop and compare every transfer; check hold while stalled.
  logic              stall_prev = 1'b0;
  logic [DATA_W:0]   held_word;
  always begin
    @(negedge clk);
    #2;
    if (!rst) begin
      if (stall_prev) begin
        check(out_valid && ({out_last, out_data} == held_word), "R6 hold",
              int'({out_last, out_data}), int'(held_word));
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected beat", int'(out_data), 0);
        end else begin
          logic [DATA_W:0] e;
          e = exp_q.pop_front();
          check(out_data == e[DATA_W-1:0], "R7 order", int'(out_data), int'(e[DATA_W-1:0]));
          check(out_last == e[DATA_W], "R9 last", int'(out_last), int'(e[DATA_W]));
        end
        n_out++;
      end
      stall_prev = out_valid && !out_ready;
      held_word  = {out_last, out_data};
    end else begin
      stall_prev = 1'b0;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int base_acc, base_out, acc_at_drop;
    bit ready_ok, seen_drop;

    repeat (3) @(negedge clk);
    #1;
    check(!out_valid, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready, "R1 in_ready after reset", int'(in_ready), 1);
    @(negedge clk);
    rst = 1'b0;
    ready_prev = 1'b0;

    // Throughput: sink always ready, beat every cycle (R2, R8).
    base_acc = n_acc;
    base_out = n_out;
    ready_ok = 1'b1;
    for (int i = 0; i < 20; i++) begin
      cycle(1'b1, (i % 5) == 4, 1'b1);
      if (!in_ready) ready_ok = 1'b0;
    end
    cycle(1'b0, 1'b0, 1'b1);
    #2;
    check(ready_ok, "R8 in_ready stays high", int'(ready_ok), 1);
    check(n_acc - base_acc == 20, "R2 accepted count", n_acc - base_acc, 20);
    check(n_out - base_out == 20, "R8 one beat per cycle", n_out - base_out, 20);

    // Fill while stalled: DEPTH-1 with ready, one late beat, rest ignored (R3 R4 R5 R10).
    base_acc = n_acc;
    seen_drop = 1'b0;
    acc_at_drop = 0;
    for (int i = 0; i < 10; i++) begin
      cycle(1'b1, 1'b0, 1'b0);
      if (!seen_drop && !in_ready) begin
        seen_drop = 1'b1;
        acc_at_drop = n_acc - base_acc - 1;
      end
    end
    check(acc_at_drop == DEPTH - 1, "R5 ready drops at DEPTH-1", acc_at_drop, DEPTH - 1);
    check(n_acc - base_acc == DEPTH, "R3 R4 R10 late beat only", n_acc - base_acc, DEPTH);
    check(!in_ready, "R5 ready low when full", int'(in_ready), 0);
    for (int i = 0; i < DEPTH + 3; i++) cycle(1'b1, 1'b0, 1'b0);
    check(n_acc - base_acc == DEPTH, "R4 still ignored", n_acc - base_acc, DEPTH);
    for (int i = 0; i < DEPTH + 3; i++) cycle(1'b0, 1'b0, 1'b1);
    #2;
    check(exp_q.size() == 0, "R7 drained after fill", exp_q.size(), 0);
    check(in_ready, "R5 ready back after drain", int'(in_ready), 1);

    // Random valid/ready/last mix (R7 R9 R6).
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cycle(lfsr[0] | lfsr[3], lfsr[5], lfsr[7] | (lfsr[9] & lfsr[2]));
    end
    for (int i = 0; i < DEPTH + 3; i++) cycle(1'b0, 1'b0, 1'b1);
    #2;
    check(exp_q.size() == 0, "R7 nothing left", exp_q.size(), 0);
    check(n_out == n_acc, "R7 out equals in", n_out, n_acc);

    finish_run();
  end
endmodule